// File: doc/BRIEF.md
# Paged Memory Management Unit

This block sits between an 8-bit CPU with a 16-bit address bus and a 2 MB external SRAM. It splits the CPU address space into eight 8 KB windows. A 16-entry file of 8-bit page registers then places each window anywhere in 256 physical pages. Two task sets of eight entries each let software switch the whole map with a single register write. A control register turns mapping on or off. When mapping is off, the CPU sees the top 64 KB of physical memory directly.

Translation is purely combinational from the CPU address to the 21-bit SRAM address. It adds no wait state, and this suits a 40 MHz clock. The CPU reads and writes the page entries and the two control registers in the $FFxx I/O page. Register reads come back combinationally on `cpu_rdata`, qualified by `reg_hit`. Every access to the $FFxx page is flagged as I/O and never selects the SRAM. An optional constant page sends $FE00–$FEFF to the last physical page, whatever the map holds. The address interface is a plain CPU bus strobe (`cpu_valid`) with no back-pressure. The CPU owns the timing, and every strobed cycle completes in that cycle.

Top module: `paged_mmu`

## Requirements
- R1: After reset the control register at $FF90 reads 0x3E, and the task register at $FF91 reads 0x00. Mapping is therefore off (bit 6 clear) and the constant page is on (bit 3 set).
- R2: A write strobed to $FFA0+n (n = 0..15) stores the 8-bit value in page entry n. The new value is used and read back from the cycle after the write edge, unchanged.
- R3: $FF90 is a full 8-bit read/write control register. Bit 6 enables mapping and bit 3 enables the constant page. $FF91 stores only its bit 0 as the task select, and it reads back with bits 7..1 as zero.
- R4: With bit 6 clear, an SRAM access outside $FE00–$FFFF produces phys_addr = {5'b11111, cpu_addr}.
- R5: With bit 6 set and task select 0, an SRAM access uses page entry cpu_addr[15:13]. It produces phys_addr = {entry, cpu_addr[12:0]}.
- R6: With bit 6 set and task select 1, the entry used is 8 + cpu_addr[15:13].
- R7: With bit 3 set, an access to $FE00–$FEFF gives phys_addr[20:13] = 0xFF in either mapping mode. With bit 3 clear, such an access follows R4 to R6.
- R8: An access to $FF00–$FFFF raises io_sel and keeps sram_sel low.
- R9: sram_sel and io_sel are high only while cpu_valid is high, and never together.
- R10: After reset, page entry n holds {5'b11111, n mod 8}. Enabling mapping without programming the entries therefore gives the same map as mapping off.
- R11: reg_hit is high exactly for a strobed read (cpu_we low) of $FF90, $FF91 or $FFA0–$FFAF, and cpu_rdata then carries that register. Otherwise cpu_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU bus cycle strobe |
| cpu_we | input | 1 | Write when high, read when low |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data, zero unless reg_hit |
| reg_hit | output | 1 | A register read is being served |
| phys_addr | output | 21 | Physical SRAM address |
| sram_sel | output | 1 | SRAM access select |
| io_sel | output | 1 | I/O page access flag |

## Verification
The bench goes after the $FE00–$FEFF window in both mapping modes and with the constant page on and off. A design that mis-prioritised the constant page would place that window through slot 7 or the identity page. It switches the task select between accesses. A design that ignored the select would return the task-0 entry where the task-1 entry was expected. It reads every page entry straight after reset and straight after a write, which catches a wrong reset pattern or a write that lands a cycle late. It also hammers the $FF00–$FFFF page and reserved register addresses, where a loose decode would raise sram_sel or report a register hit for an address with no register behind it.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int CPU_AW   = 16;
  localparam int DW       = 8;
  localparam int OFS_W    = 13;
  localparam int SLOT_W   = CPU_AW - OFS_W;
  localparam int IDX_W    = SLOT_W + 1;
  localparam int N_ENTRY  = 1 << IDX_W;
  localparam int PA_W     = DW + OFS_W;
  localparam int EN_BIT   = 6;
  localparam int CONST_BIT = 3;

  localparam logic [CPU_AW-1:0] CTRL_ADDR = 16'hFF90;
  localparam logic [CPU_AW-1:0] TASK_ADDR = 16'hFF91;
  localparam logic [CPU_AW-1:0] PAGE_BASE = 16'hFFA0;
  localparam logic [DW-1:0]     CTRL_RST  = 8'h3E;
  localparam logic [7:0]        IO_HI     = 8'hFF;
  localparam logic [7:0]        CONST_HI  = 8'hFE;

  typedef struct packed {
    logic mmu_en;
    logic const_en;
    logic task_sel;
  } mmu_mode_t;
endpackage

// File: rtl/mmu_page_file.sv
module mmu_page_file
  import mmu_pkg::*;
#(
  parameter int P_DW     = DW,
  parameter int P_SLOT_W = SLOT_W,
  parameter int P_IDX_W  = IDX_W,
  parameter int P_N      = N_ENTRY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [P_IDX_W-1:0] wr_idx,
  input  logic [P_DW-1:0]    wr_data,
  input  logic [P_IDX_W-1:0] xl_idx,
  input  logic [P_IDX_W-1:0] bus_idx,
  output logic [P_DW-1:0]    xl_page,
  output logic [P_DW-1:0]    bus_page
);
  logic [P_DW-1:0] entry_q [P_N];

  for (genvar g = 0; g < P_N; g++) begin : g_entry
    localparam logic [P_DW-1:0] RST_VAL =
      {{(P_DW-P_SLOT_W){1'b1}}, P_SLOT_W'(g % (1 << P_SLOT_W))};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[g] <= RST_VAL;
      else if (wr_en && (wr_idx == P_IDX_W'(g)))
        entry_q[g] <= wr_data;
    end
  end

  assign xl_page  = entry_q[xl_idx];
  assign bus_page = entry_q[bus_idx];
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_pkg::*;
#(
  parameter int P_DW = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_task,
  input  logic [P_DW-1:0] wr_data,
  output logic [P_DW-1:0] ctrl_q,
  output logic            task_q,
  output mmu_mode_t       mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      task_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_task) task_q <= wr_data[0];
    end
  end

  always_comb begin
    mode.mmu_en   = ctrl_q[EN_BIT];
    mode.const_en = ctrl_q[CONST_BIT];
    mode.task_sel = task_q;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int P_AW     = CPU_AW,
  parameter int P_DW     = DW,
  parameter int P_OFS_W  = OFS_W,
  parameter int P_SLOT_W = SLOT_W,
  parameter int P_IDX_W  = IDX_W,
  parameter int P_PA_W   = PA_W
) (
  input  logic               cpu_valid,
  input  logic [P_AW-1:0]    cpu_addr,
  input  mmu_mode_t          mode,
  output logic [P_IDX_W-1:0] entry_idx,
  input  logic [P_DW-1:0]    entry_val,
  output logic [P_PA_W-1:0]  phys_addr,
  output logic               sram_sel,
  output logic               io_sel
);
  logic [7:0]          hi_byte;
  logic [P_SLOT_W-1:0] slot;
  logic                in_io;
  logic                in_const;
  logic [P_DW-1:0]     page;

  assign hi_byte   = cpu_addr[P_AW-1 -: 8];
  assign slot      = cpu_addr[P_AW-1 -: P_SLOT_W];
  assign in_io     = (hi_byte == IO_HI);
  assign in_const  = mode.const_en && (hi_byte == CONST_HI);
  assign entry_idx = {mode.task_sel, slot};

  always_comb begin
    if (in_const)
      page = '1;
    else if (!mode.mmu_en)
      page = {{(P_DW-P_SLOT_W){1'b1}}, slot};
    else
      page = entry_val;
  end

  assign phys_addr = {page, cpu_addr[P_OFS_W-1:0]};
  assign sram_sel  = cpu_valid && !in_io;
  assign io_sel    = cpu_valid && in_io;
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              reg_hit,
  output logic [PA_W-1:0]   phys_addr,
  output logic              sram_sel,
  output logic              io_sel
);
  logic            hit_ctrl, hit_task, hit_page;
  logic            wr_strobe, rd_strobe;
  logic [DW-1:0]   ctrl_q;
  logic            task_q;
  mmu_mode_t       mode;
  logic [IDX_W-1:0] xl_idx;
  logic [DW-1:0]   xl_page, bus_page;

  assign hit_ctrl  = (cpu_addr == CTRL_ADDR);
  assign hit_task  = (cpu_addr == TASK_ADDR);
  assign hit_page  = (cpu_addr[CPU_AW-1:IDX_W] == PAGE_BASE[CPU_AW-1:IDX_W]);
  assign wr_strobe = cpu_valid && cpu_we;
  assign rd_strobe = cpu_valid && !cpu_we;

  mmu_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_strobe && hit_ctrl),
    .wr_task (wr_strobe && hit_task),
    .wr_data (cpu_wdata),
    .ctrl_q  (ctrl_q),
    .task_q  (task_q),
    .mode    (mode)
  );

  mmu_page_file u_pages (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_strobe && hit_page),
    .wr_idx   (cpu_addr[IDX_W-1:0]),
    .wr_data  (cpu_wdata),
    .xl_idx   (xl_idx),
    .bus_idx  (cpu_addr[IDX_W-1:0]),
    .xl_page  (xl_page),
    .bus_page (bus_page)
  );

  mmu_xlate u_xlate (
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .mode      (mode),
    .entry_idx (xl_idx),
    .entry_val (xl_page),
    .phys_addr (phys_addr),
    .sram_sel  (sram_sel),
    .io_sel    (io_sel)
  );

  assign reg_hit = rd_strobe && (hit_ctrl || hit_task || hit_page);

  always_comb begin
    cpu_rdata = '0;
    if (rd_strobe) begin
      if (hit_ctrl)      cpu_rdata = ctrl_q;
      else if (hit_task) cpu_rdata = {{(DW-1){1'b0}}, task_q};
      else if (hit_page) cpu_rdata = bus_page;
    end
  end
endmodule

// File: rtl/paged_mmu_chk.sv
module paged_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [20:0] phys_addr,
  input logic        sram_sel,
  input logic        io_sel,
  input logic        reg_hit,
  input logic [7:0]  ctrl_q,
  input logic        task_q
);
  AST_RESET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == 8'h3E) && !task_q); // R1

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && cpu_addr == 16'hFF90) |=> (ctrl_q == $past(cpu_wdata))); // R3

  AST_IDENTITY_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !ctrl_q[6] && cpu_addr[15:9] != 7'h7F) |-> (phys_addr == {5'h1F, cpu_addr})); // R4

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_sel |-> (phys_addr[12:0] == cpu_addr[12:0])); // R5

  AST_CONST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && ctrl_q[3] && cpu_addr[15:8] == 8'hFE) |-> (phys_addr[20:13] == 8'hFF) && sram_sel); // R7

  AST_IO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15:8] == 8'hFF) |-> io_sel && !sram_sel); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> !sram_sel && !io_sel && !reg_hit); // R9

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_sel, io_sel})); // R9

  AST_HIT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> cpu_valid && !cpu_we && io_sel); // R11
endmodule

bind paged_mmu paged_mmu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .phys_addr (phys_addr),
  .sram_sel  (sram_sel),
  .io_sel    (io_sel),
  .reg_hit   (reg_hit),
  .ctrl_q    (ctrl_q),
  .task_q    (task_q)
);

// File: tb/paged_mmu_tb.sv
module paged_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        reg_hit;
  logic [20:0] phys_addr;
  logic        sram_sel;
  logic        io_sel;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  // reference state
  int m_page [16];
  int m_ctrl;
  int m_task;
  bit pages_fresh;
  bit ctrl_fresh;

  always #10 clk = ~clk;

  paged_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .reg_hit(reg_hit), .phys_addr(phys_addr), .sram_sel(sram_sel), .io_sel(io_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", tag, cpu_addr, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit w, input int a, input int d);
    int  hi, slot, page, exp_rd;
    bit  io, hit;
    string ptag, rtag;
    @(negedge clk);
    cpu_valid = v; cpu_we = w; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
    #2;
    hi   = a / 256;
    slot = a / 8192;
    io   = (hi == 255);
    if ((m_ctrl & 8) != 0 && hi == 254) begin page = 255; ptag = "R7"; end
    else if ((m_ctrl & 64) == 0) begin page = 248 + slot; ptag = "R4"; end
    else if (m_task == 0) begin page = m_page[slot]; ptag = "R5"; end
    else begin page = m_page[8 + slot]; ptag = "R6"; end
    check("R9", sram_sel, (v && !io) ? 1 : 0);
    if (io) check("R8", io_sel, v ? 1 : 0);
    else    check("R9", io_sel, 0);
    if (v && !io) check(ptag, phys_addr, page * 8192 + (a % 8192));
    hit = 0; exp_rd = 0; rtag = "R11";
    if (v && !w) begin
      if (a == 'hFF90) begin hit = 1; exp_rd = m_ctrl; rtag = ctrl_fresh ? "R1" : "R3"; end
      else if (a == 'hFF91) begin hit = 1; exp_rd = m_task; rtag = ctrl_fresh ? "R1" : "R3"; end
      else if (a >= 'hFFA0 && a <= 'hFFAF) begin
        hit = 1; exp_rd = m_page[a - 'hFFA0]; rtag = pages_fresh ? "R10" : "R2";
      end
    end
    check("R11", reg_hit, hit);
    check(rtag, cpu_rdata, exp_rd);
    @(posedge clk);
    if (v && w) begin
      if (a == 'hFF90) begin m_ctrl = d; ctrl_fresh = 0; end
      else if (a == 'hFF91) begin m_task = d % 2; ctrl_fresh = 0; end
      else if (a >= 'hFFA0 && a <= 'hFFAF) begin m_page[a - 'hFFA0] = d; pages_fresh = 0; end
    end
  endtask

  function automatic int pick_addr();
    int r;
    r = $urandom % 10;
    case (r)
      0, 1, 2, 3, 4: pick_addr = $urandom % 'hFE00;
      5:             pick_addr = 'hFE00 + $urandom % 256;
      6:             pick_addr = 'hFF00 + $urandom % 256;
      7:             pick_addr = 'hFF90 + $urandom % 2;
      default:       pick_addr = 'hFFA0 + $urandom % 16;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_page[i] = 248 + (i % 8);
    m_ctrl = 'h3E; m_task = 0; pages_fresh = 1; ctrl_fresh = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 / R10: reset state read back
    step(1, 0, 'hFF90, 0);
    step(1, 0, 'hFF91, 0);
    for (int i = 0; i < 16; i++) step(1, 0, 'hFFA0 + i, 0);
    // R4 identity map, R7 constant page, R8 io page, R9 idle
    for (int i = 0; i < 8; i++) step(1, 0, i * 8192 + 'h123, 0);
    step(1, 0, 'hFE42, 0);
    step(1, 1, 'hFF20, 'h55);
    step(0, 0, 'h4000, 0);
    // R10: enable mapping unprogrammed -> same map
    step(1, 1, 'hFF90, 'h48);
    for (int i = 0; i < 8; i++) step(1, 0, i * 8192 + 'h1ABC, 0);
    // R2: program entries, read back next cycle
    for (int i = 0; i < 16; i++) step(1, 1, 'hFFA0 + i, 'h10 + 13 * i);
    for (int i = 0; i < 16; i++) step(1, 0, 'hFFA0 + i, 0);
    // R5 then R6 via task switch
    for (int i = 0; i < 8; i++) step(1, 0, i * 8192 + 'h0777, 0);
    step(1, 1, 'hFF91, 'hFF);
    step(1, 0, 'hFF91, 0);
    for (int i = 0; i < 8; i++) step(1, 0, i * 8192 + 'h1FFF, 0);
    // R7: constant page off -> FExx goes through slot 7
    step(1, 0, 'hFE10, 0);
    step(1, 1, 'hFF90, 'h40);
    step(1, 0, 'hFE10, 0);
    step(1, 0, 'hFDFF, 0);
    step(1, 1, 'hFF90, 'h00);
    step(1, 0, 'hFE10, 0);
    // R11: reserved io addresses and writes do not hit
    step(1, 0, 'hFF92, 0);
    step(1, 0, 'hFF9F, 0);
    step(1, 1, 'hFFA3, 'h77);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int a;
      bit w;
      a = pick_addr();
      w = (a >= 'hFF00) && ($urandom % 2 == 1);
      step($urandom % 8 != 0, w, a, $urandom % 256);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R9: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule